// File: doc/BRIEF.md
# Oversampled Reader Frame Decoder

This block recovers reader-to-card frames of the proximity-card Type B style from a stream of single-bit demodulated line samples. The line is oversampled at four samples per elementary time unit (etu). One sample is offered per clock with a valid strobe. A frame opens with a long low start-of-frame period that ends on a rising edge. Characters follow, each ten bits long: a low start bit, eight data bits sent least significant bit first, and a high stop bit. Every start bit realigns the bit timing, so slow drift between reader and decoder does not build up over the frame.

Each good data byte leaves the block on a byte-write port that carries a sequential address from zero. A frame ends in one of two ways: an all-low character arrives after at least one byte, or the stored byte count reaches a programmable ceiling. Either way the block pulses a frame-done strobe and holds the byte count on a length output. A character with bad framing pulses an error strobe, and the decoder goes back to hunting for a new start-of-frame. The write port has no back-pressure: the sink must accept every write in the cycle it appears. A sample is accepted in the cycle its valid strobe is high, and there is no ready signal. Analog demodulation and CRC checking belong to the blocks around this one.

Top module: `rfd_frame_decoder`

## Requirements
- R1: A synchronous active-low reset clears the decoder to the hunting state and drives wr_valid, frame_done and char_err low and frame_len to zero.
- R2: Only samples with smp_valid high are acted on. A cycle with smp_valid low changes no state, produces no write, done or error, and the smp_bit value in that cycle is ignored.
- R3: A low sample in the hunting state begins start-of-frame timing. The line is judged at the middle sample of each etu. If a high middle sample follows at least 10 low middle samples, the start-of-frame is accepted. If it follows fewer than 10, the attempt is dropped. A 13th consecutive low middle sample aborts the attempt.
- R4: Between characters the line may stay high for at most 25 counted samples. The count includes the stop-bit samples that follow its middle sample. The 26th high sample returns the decoder to hunting.
- R5: Each bit is judged on its third sample, counting the falling-edge sample of the start bit as the first. Every start bit restarts this timing.
- R6: A character is good when its stop bit is 1 and its start bit is 0. Its eight data bits, first received in bit 0, are written with wr_valid high for one cycle. The write appears in the clock after the stop bit's middle sample is accepted, at wr_addr 0, 1, 2 and so on within the frame.
- R7: When the stored byte count reaches max_bytes, frame_done pulses with frame_len equal to that count and the decoder returns to hunting. A max_bytes of 0 behaves as 1, and values above the MAX_FRAME parameter (default 64) behave as MAX_FRAME.
- R8: An all-zero ten-bit character received after one or more bytes ends the frame: frame_done pulses for one cycle and frame_len shows the number of bytes stored.
- R9: Any other bad character pulses char_err for one cycle, produces no write and no frame_done, and returns the decoder to hunting. This includes an all-zero character with no bytes stored.
- R10: frame_done and char_err are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; smp_bit is taken in this cycle |
| smp_bit | input | 1 | Demodulated line level, 1 = high |
| max_bytes | input | LEN_W (7) | Byte ceiling for one frame |
| wr_valid | output | 1 | Byte write strobe |
| wr_addr | output | LEN_W (7) | Byte position within the frame |
| wr_data | output | DATA_W (8) | Received data byte |
| frame_done | output | 1 | One-cycle pulse at frame end |
| frame_len | output | LEN_W (7) | Bytes in the last finished frame, held |
| char_err | output | 1 | One-cycle pulse on a badly framed character |

## Verification
The assertions assume that max_bytes stays steady while a frame is being received, because the length ceiling is checked against the value seen in the cycle the frame closed. They also assume that each sample appears for exactly one accepted valid cycle. The stimulus sets max_bytes only between frames, while reset is held. Stall cycles are inserted at a fixed rhythm and during them smp_bit is deliberately toggled, so the ignore rule is tested with hostile data. Every frame is built from whole four-sample bits, with gap lengths chosen to sit exactly on either side of the idle limit.

// File: rtl/rfd_pkg.sv
package rfd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SOF  = 2'd1,
    ST_GAP  = 2'd2,
    ST_CHAR = 2'd3
  } rfd_state_e;

  function automatic int unsigned rfd_max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfd_phase_ctr.sv
module rfd_phase_ctr #(
  parameter int SPB     = 4,
  parameter int PW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          wrap_en,
  output logic [PW-1:0] pos_inc,
  output logic          mid
);
  localparam logic [PW-1:0] SPB_V = PW'(SPB);
  localparam logic [PW-1:0] MID_V = PW'(SPB / 2);
  localparam logic [PW-1:0] TOP_V = '1;

  logic [PW-1:0] pos;

  assign pos_inc = (pos == TOP_V) ? pos : pos + 1'b1;
  assign mid     = (pos_inc == MID_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (clr) begin
      pos <= '0;
    end else if (adv) begin
      if (wrap_en && (pos_inc >= SPB_V)) pos <= '0;
      else                               pos <= pos_inc;
    end
  end

endmodule

// File: rtl/rfd_char_shift.sv
module rfd_char_shift #(
  parameter int CHAR_W  = 10,
  parameter int CW      = 4,
  parameter int CNT_TOP = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              bit_in,
  output logic [CHAR_W-1:0] shifted,
  output logic [CW-1:0]     cnt,
  output logic [CW-1:0]     cnt_inc
);
  logic [CHAR_W-1:0] sh;

  assign shifted = {bit_in, sh[CHAR_W-1:1]};
  assign cnt_inc = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sh  <= '0;
      cnt <= '0;
    end else if (step) begin
      sh  <= shifted;
      cnt <= cnt_inc;
    end
  end

  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CNT_TOP)) else $error("bit counter past its ceiling"); // R3

endmodule

// File: rtl/rfd_frame_fsm.sv
module rfd_frame_fsm
  import rfd_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SOF_MIN   = 10,
  parameter int SOF_MAX   = 12,
  parameter int GAP_MAX   = 25,
  parameter int MAX_FRAME = 64,
  parameter int CHAR_W    = DATA_W + 2,
  parameter int CW        = 4,
  parameter int PW        = 5,
  parameter int LEN_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_bit,
  input  logic [LEN_W-1:0]  max_bytes,
  input  logic [PW-1:0]     pos_inc,
  input  logic              mid,
  input  logic [CHAR_W-1:0] shifted,
  input  logic [CW-1:0]     cnt,
  input  logic [CW-1:0]     cnt_inc,
  output logic              p_clr,
  output logic              p_adv,
  output logic              p_wrap,
  output logic              c_clr,
  output logic              c_step,
  output logic              wr_valid,
  output logic [LEN_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              char_err
);
  localparam logic [CW-1:0]    SOF_MIN_V = CW'(SOF_MIN);
  localparam logic [CW-1:0]    SOF_MAX_V = CW'(SOF_MAX);
  localparam logic [CW-1:0]    CHAR_V    = CW'(CHAR_W);
  localparam logic [PW-1:0]    GAP_V     = PW'(GAP_MAX);
  localparam logic [LEN_W-1:0] FRAME_V   = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0] ONE_V     = LEN_W'(1);

  rfd_state_e       st, st_n;
  logic [LEN_W-1:0] bytes, bytes_n, bytes_inc, lim, len_n;
  logic             wr_n, done_n, err_n;
  logic             char_ok, char_eof;

  assign lim       = (max_bytes == '0) ? ONE_V :
                     ((max_bytes > FRAME_V) ? FRAME_V : max_bytes);
  assign bytes_inc = bytes + 1'b1;
  assign char_ok   = shifted[CHAR_W-1] & ~shifted[0];
  assign char_eof  = (shifted == '0);

  always_comb begin
    st_n    = st;
    bytes_n = bytes;
    len_n   = frame_len;
    p_clr   = 1'b0;
    p_adv   = 1'b0;
    p_wrap  = 1'b1;
    c_clr   = 1'b0;
    c_step  = 1'b0;
    wr_n    = 1'b0;
    done_n  = 1'b0;
    err_n   = 1'b0;
    if (smp_valid) begin
      unique case (st)
        ST_HUNT: begin
          if (!smp_bit) begin
            st_n  = ST_SOF;
            p_clr = 1'b1;
            c_clr = 1'b1;
          end
        end
        ST_SOF: begin
          p_adv = 1'b1;
          if (mid) begin
            if (smp_bit) begin
              if (cnt >= SOF_MIN_V) begin
                st_n    = ST_GAP;
                p_clr   = 1'b1;
                bytes_n = '0;
              end else begin
                st_n = ST_HUNT;
              end
            end else begin
              c_step = 1'b1;
              if (cnt_inc > SOF_MAX_V) st_n = ST_HUNT;
            end
          end
        end
        ST_GAP: begin
          if (smp_bit) begin
            p_adv  = 1'b1;
            p_wrap = 1'b0;
            if (pos_inc > GAP_V) st_n = ST_HUNT;
          end else begin
            st_n  = ST_CHAR;
            p_clr = 1'b1;
            c_clr = 1'b1;
          end
        end
        ST_CHAR: begin
          p_adv = 1'b1;
          if (mid) begin
            c_step = 1'b1;
            if (cnt_inc == CHAR_V) begin
              if (char_ok) begin
                wr_n    = 1'b1;
                bytes_n = bytes_inc;
                if (bytes_inc >= lim) begin
                  done_n = 1'b1;
                  len_n  = bytes_inc;
                  st_n   = ST_HUNT;
                end else begin
                  st_n  = ST_GAP;
                  p_clr = 1'b1;
                end
              end else if (char_eof && (bytes != '0)) begin
                done_n = 1'b1;
                len_n  = bytes;
                st_n   = ST_HUNT;
              end else begin
                err_n = 1'b1;
                st_n  = ST_HUNT;
              end
            end
          end
        end
        default: st_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_HUNT;
      bytes      <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      frame_done <= 1'b0;
      frame_len  <= '0;
      char_err   <= 1'b0;
    end else begin
      st         <= st_n;
      bytes      <= bytes_n;
      wr_valid   <= wr_n;
      frame_done <= done_n;
      frame_len  <= len_n;
      char_err   <= err_n;
      if (wr_n) begin
        wr_addr <= bytes;
        wr_data <= shifted[DATA_W:1];
      end
    end
  end

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !char_err) else $error("done and error together"); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done) else $error("done longer than a cycle"); // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    char_err |=> !char_err) else $error("error longer than a cycle"); // R9
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !(wr_valid || frame_done || char_err)) else $error("output on stall"); // R2
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len != '0)) else $error("empty frame reported"); // R8
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_len <= (($past(max_bytes) == '0) ? ONE_V :
                   (($past(max_bytes) > FRAME_V) ? FRAME_V : $past(max_bytes)))))
    else $error("frame longer than ceiling"); // R7

endmodule

// File: rtl/rfd_frame_decoder.sv
module rfd_frame_decoder
  import rfd_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SPB       = 4,
  parameter int SOF_MIN   = 10,
  parameter int SOF_MAX   = 12,
  parameter int GAP_MAX   = 25,
  parameter int MAX_FRAME = 64,
  parameter int LEN_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic              smp_bit,
  input  logic [LEN_W-1:0]  max_bytes,
  output logic              wr_valid,
  output logic [LEN_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              char_err
);
  localparam int CHAR_W  = DATA_W + 2;
  localparam int CNT_TOP = rfd_max2(SOF_MAX + 1, CHAR_W);
  localparam int CW      = $clog2(CNT_TOP + 2);
  localparam int PW      = $clog2(rfd_max2(GAP_MAX + 2, SPB + 1) + 1);

  logic              p_clr, p_adv, p_wrap, mid;
  logic [PW-1:0]     pos_inc;
  logic              c_clr, c_step;
  logic [CHAR_W-1:0] shifted;
  logic [CW-1:0]     cnt, cnt_inc;

  rfd_phase_ctr #(.SPB(SPB), .PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(p_clr), .adv(p_adv), .wrap_en(p_wrap),
    .pos_inc(pos_inc), .mid(mid)
  );

  rfd_char_shift #(.CHAR_W(CHAR_W), .CW(CW), .CNT_TOP(CNT_TOP)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(c_clr), .step(c_step), .bit_in(smp_bit),
    .shifted(shifted), .cnt(cnt), .cnt_inc(cnt_inc)
  );

  rfd_frame_fsm #(
    .DATA_W(DATA_W), .SOF_MIN(SOF_MIN), .SOF_MAX(SOF_MAX), .GAP_MAX(GAP_MAX),
    .MAX_FRAME(MAX_FRAME), .CHAR_W(CHAR_W), .CW(CW), .PW(PW), .LEN_W(LEN_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bit(smp_bit),
    .max_bytes(max_bytes), .pos_inc(pos_inc), .mid(mid), .shifted(shifted),
    .cnt(cnt), .cnt_inc(cnt_inc), .p_clr(p_clr), .p_adv(p_adv), .p_wrap(p_wrap),
    .c_clr(c_clr), .c_step(c_step), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_done(frame_done), .frame_len(frame_len),
    .char_err(char_err)
  );

endmodule

// File: tb/rfd_frame_decoder_tb_top.sv
module rfd_frame_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_bit = 1'b1;
  logic [6:0] max_bytes = 7'd8;
  logic       wr_valid, frame_done, char_err;
  logic [6:0] wr_addr, frame_len;
  logic [7:0] wr_data;

  int n_cmp = 0, n_bad = 0, stall_ctr = 0;
  bit started = 0;

  always #10 clk = ~clk;

  rfd_frame_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bit(smp_bit),
    .max_bytes(max_bytes), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_done(frame_done), .frame_len(frame_len),
    .char_err(char_err)
  );

  // behavioural reference, advanced on each clock
  int m_st, m_pos, m_nb, m_sh, m_bytes, m_lim;
  bit e_wr, e_done, e_err;
  int e_addr, e_data, e_len;

  always @(posedge clk) begin
    started <= 1;
    e_wr = 0; e_done = 0; e_err = 0;
    if (!rst_n) begin
      m_st = 0; m_pos = 0; m_nb = 0; m_sh = 0; m_bytes = 0;
      e_addr = 0; e_data = 0; e_len = 0;
    end else if (smp_valid) begin
      m_lim = (max_bytes == 0) ? 1 : ((max_bytes > 64) ? 64 : int'(max_bytes));
      case (m_st)
        0: if (!smp_bit) begin m_st = 1; m_pos = 0; m_nb = 0; end
        1: begin
          m_pos++;
          if (m_pos == 2) begin
            if (smp_bit) begin
              if (m_nb >= 10) begin m_st = 2; m_pos = 0; m_bytes = 0; end
              else m_st = 0;
            end else begin
              m_nb++;
              if (m_nb > 12) m_st = 0;
            end
          end
          if (m_pos >= 4) m_pos = 0;
        end
        2: if (smp_bit) begin
             m_pos++;
             if (m_pos > 25) m_st = 0;
           end else begin
             m_st = 3; m_pos = 0; m_nb = 0; m_sh = 0;
           end
        default: begin
          m_pos++;
          if (m_pos == 2) begin
            m_sh = (m_sh >> 1) | (smp_bit ? 512 : 0);
            m_nb++;
            if (m_nb == 10) begin
              if ((m_sh & 512) != 0 && (m_sh & 1) == 0) begin
                e_wr = 1; e_addr = m_bytes; e_data = (m_sh >> 1) & 255;
                m_bytes++;
                if (m_bytes >= m_lim) begin e_done = 1; e_len = m_bytes; m_st = 0; end
                else begin m_st = 2; m_pos = 0; end
              end else if (m_sh == 0 && m_bytes > 0) begin
                e_done = 1; e_len = m_bytes; m_st = 0;
              end else begin
                e_err = 1; m_st = 0;
              end
            end
          end
          if (m_pos >= 4) m_pos = 0;
        end
      endcase
    end
  end

  // per-cycle comparison and event capture
  logic [7:0] got_q[$];
  int done_cnt, err_cnt, last_len;

  always @(negedge clk) begin
    if (started) begin
      n_cmp++;
      if (wr_valid !== e_wr || (e_wr && (wr_addr !== 7'(e_addr) || wr_data !== 8'(e_data)))) begin
        n_bad++;
        $display("FAIL R6 write: actual v=%0b a=%0d d=%02h expected v=%0b a=%0d d=%02h",
                 wr_valid, wr_addr, wr_data, e_wr, e_addr, e_data);
      end
      n_cmp++;
      if (frame_done !== e_done || frame_len !== 7'(e_len)) begin
        n_bad++;
        $display("FAIL R8 done/len: actual %0b/%0d expected %0b/%0d",
                 frame_done, frame_len, e_done, e_len);
      end
      n_cmp++;
      if (char_err !== e_err) begin
        n_bad++;
        $display("FAIL R9 err: actual %0b expected %0b", char_err, e_err);
      end
      if (wr_valid) got_q.push_back(wr_data);
      if (frame_done) begin done_cnt++; last_len = int'(frame_len); end
      if (char_err) err_cnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // each push leaves the bench at a falling edge
  task automatic push(input logic b);
    stall_ctr++;
    if (stall_ctr % 7 == 0) begin
      smp_valid = 0; smp_bit = ~b; @(negedge clk);   // hostile data on a stall (R2)
    end
    smp_valid = 1; smp_bit = b; @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic bits(input logic b, input int n);
    for (int i = 0; i < n; i++) push(b);
  endtask

  task automatic sof(input int nlow);
    bits(0, nlow * 4); bits(1, 8);
  endtask

  task automatic chr(input logic [7:0] d);
    bits(0, 4);
    for (int i = 0; i < 8; i++) bits(d[i], 4);
    bits(1, 4);
  endtask

  task automatic raw10(input logic [9:0] v);
    for (int i = 0; i < 10; i++) bits(v[i], 4);
  endtask

  task automatic eof();
    bits(0, 40); bits(1, 8);
  endtask

  task automatic restart(input logic [6:0] mx);
    rst_n = 0; max_bytes = mx;
    repeat (2) @(negedge clk);
    rst_n = 1;
    got_q.delete(); done_cnt = 0; err_cnt = 0; last_len = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    restart(7'd8);
    // R1: reset state
    check(!wr_valid && !frame_done && !char_err && frame_len == 0, "R1 reset outputs", int'(frame_len), 0);

    // normal frame, data 0x00 is a good byte, gap 24 extra samples accepted
    sof(11); chr(8'hA5); chr(8'h3C); bits(1, 24); chr(8'h00); chr(8'hFF); eof();
    check(got_q.size() == 4, "R6 byte count", got_q.size(), 4);
    if (got_q.size() == 4) begin
      check(got_q[0] == 8'hA5, "R5 byte0 lsb-first", got_q[0], 8'hA5);
      check(got_q[2] == 8'h00, "R6 zero data byte", got_q[2], 0);
      check(got_q[3] == 8'hFF, "R6 byte3", got_q[3], 8'hFF);
    end
    check(done_cnt == 1 && last_len == 4, "R8 eof frame length", last_len, 4);
    check(err_cnt == 0, "R4 gap 24 tolerated", err_cnt, 0);

    // R4: 25 extra high samples exceeds the limit
    restart(7'd8);
    sof(10); chr(8'h12); bits(1, 25); chr(8'h34); eof();
    check(got_q.size() == 1, "R4 gap too long", got_q.size(), 1);
    check(done_cnt == 0, "R4 no done after timeout", done_cnt, 0);

    // R3: boundaries of the low period
    restart(7'd8);
    sof(9); chr(8'h55); eof();
    check(got_q.size() == 0, "R3 sof 9 rejected", got_q.size(), 0);
    restart(7'd8);
    sof(10); chr(8'h81); eof();
    check(got_q.size() == 1 && done_cnt == 1 && last_len == 1, "R3 sof 10 accepted", last_len, 1);
    restart(7'd8);
    sof(12); chr(8'h6E); eof();
    check(done_cnt == 1 && last_len == 1, "R3 sof 12 accepted", last_len, 1);
    restart(7'd8);
    sof(13); chr(8'h6E); eof();
    check(got_q.size() == 0 && done_cnt == 0, "R3 sof 13 aborted", got_q.size(), 0);

    // R7: ceiling of two bytes
    restart(7'd2);
    sof(10); chr(8'h11); chr(8'h22); chr(8'hFE); eof();
    check(done_cnt == 1 && last_len == 2, "R7 ceiling length", last_len, 2);
    check(got_q.size() == 2, "R7 third byte dropped", got_q.size(), 2);
    // R7: ceiling value 0 behaves as 1
    restart(7'd0);
    sof(10); chr(8'h99); chr(8'hFE); eof();
    check(done_cnt == 1 && last_len == 1, "R7 zero ceiling", last_len, 1);

    // R9: bad stop bit
    restart(7'd8);
    sof(10); chr(8'h11); raw10({1'b0, 8'h3C, 1'b0}); bits(1, 40);
    check(err_cnt == 1 && done_cnt == 0, "R9 bad stop", err_cnt, 1);
    check(got_q.size() == 1, "R9 no write on bad char", got_q.size(), 1);
    // R9: all-zero with no bytes
    restart(7'd8);
    sof(10); eof();
    check(err_cnt == 1 && done_cnt == 0, "R9 empty eof", err_cnt, 1);

    // R2: long stall with the line high inside the low period
    restart(7'd8);
    bits(0, 20);
    smp_valid = 0; smp_bit = 1; repeat (30) @(negedge clk);
    bits(0, 20); bits(1, 8); chr(8'h77); eof();
    check(done_cnt == 1 && got_q.size() == 1, "R2 stall ignored", got_q.size(), 1);
    // R10 is watched by assertions; confirm separate pulses here
    check(done_cnt == 1 && err_cnt == 0, "R10 pulses distinct", err_cnt, 0);

    bits(1, 10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule